// File: doc/BRIEF.md
# Atomic Register Access Bridge

This bridge sits between a processor bus and a bank of 32-bit registers. It lets one plain store carry a complete partial update. The address of each access selects two things: the target register and an operation window. The available operations are a plain read or write, a bit set, a bit clear, and a masked write of a nibble, a byte or a halfword. For a masked write, the mask and the data share the single write word. The bridge performs every modifying operation inside the block as a fetch, merge and store sequence on the addressed register. Software therefore never needs its own read-modify-write, and no other bus access can land between the read and the write.

Accesses are 8, 16 or 32 bits wide. The low three address bits give the lane or element offset. The size and window of each access are checked, and the bridge answers with a response that carries either read data or an error flag. A small register file inside the block stands in for the slave bank.

Top module: `atomic_rmw_bridge`

## Requirements
- R1: Address fields are decoded as follows. Bits [10:7] are the window code: 0 is direct, 1 is set, 2 is clear, 4 is nibble-masked, 6 is byte-masked and 8 is halfword-masked. Any other code is an error. Bits [6:3] must be zero, or the access is an error. Bits [2:0] are the sub-offset. The bits above bit 10 are the register index. Sizes are coded 0 for byte, 1 for halfword and 2 for word, and code 3 is an error.
- R2: A direct write replaces only the addressed byte lanes, taking the operand from the low bits of the write data. A word access needs sub-offset 0, a halfword needs 0 or 2, and a byte accepts 0 to 3.
- R3: A set access ORs the lane-placed operand into the register. Its size and alignment rules are the same as for a direct write.
- R4: A clear access zeroes every register bit that is 1 in the lane-placed operand. Its size and alignment rules are the same as for a direct write.
- R5: The nibble-masked window takes byte writes only. Write bits [7:4] are the mask and bits [3:0] are the data, and sub-offset n (0 to 7) targets register bits [4n+3:4n]. Only bits whose mask bit is 1 change.
- R6: The byte-masked window takes halfword writes at even sub-offsets only. Write bits [15:8] are the mask and bits [7:0] are the data, and the target byte is the sub-offset divided by 2.
- R7: The halfword-masked window takes word writes at sub-offset 0 or 4 only. Write bits [31:16] are the mask and bits [15:0] are the data. Offset 0 targets register bits [15:0] and offset 4 targets bits [31:16].
- R8: Reads are legal only in the direct window, and only as byte or halfword accesses. They return the addressed field right-justified and zero-extended, with the response in the cycle after acceptance.
- R9: An access that breaks a size, alignment, window or read rule leaves every register unchanged. Its response is a one-cycle `rsp_err` with zero read data.
- R10: A register index at or above NUM_REGS gives the error response of R9.
- R11: After a legal write is accepted, `req_ready` is low for exactly three cycles. The register takes its new value at the third edge, and `rsp_valid` with `rsp_err` low shows in the cycle after that edge.
- R12: After reset, all registers read zero, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_size | input | 2 | Access size code |
| req_addr | input | 11+IDX_W | Register index, window code, sub-offset |
| req_wdata | input | 32 | Write operand, right-justified |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Read data, zero-extended |

## Verification
The cases that are hardest to reach from the ports lie at the edges of the legality rules. Examples are a size that suits one window arriving in another, a misaligned sub-offset, a read aimed at a modifying window, and an index just past the last register. Random stimulus draws from all the window codes, including the undefined ones, and from all four size codes and every sub-offset. It also sometimes sets the pad bits, so illegal combinations come up often. After each legal write, halfword read-backs confirm that no bits outside the targeted field moved. Directed accesses replay each operation at its extreme offsets.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int LOCAL_W = 11;
  localparam int WIN_W   = 4;
  localparam int WIN_LSB = 7;
  localparam int SUB_W   = 3;
  localparam int DATA_W  = 32;

  localparam logic [WIN_W-1:0] WIN_DIRECT = 4'h0;
  localparam logic [WIN_W-1:0] WIN_SET    = 4'h1;
  localparam logic [WIN_W-1:0] WIN_CLEAR  = 4'h2;
  localparam logic [WIN_W-1:0] WIN_NIB    = 4'h4;
  localparam logic [WIN_W-1:0] WIN_BYTE   = 4'h6;
  localparam logic [WIN_W-1:0] WIN_HALF   = 4'h8;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [2:0] {
    OP_DIR, OP_SET, OP_CLR, OP_NIB, OP_BYT, OP_HLF, OP_BAD
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_FETCH, ST_MERGE, ST_STORE
  } state_e;

  typedef struct packed {
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] data;
  } merge_t;
endpackage

// File: rtl/rmw_decode.sv
module rmw_decode
  import rmw_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 3,
  localparam int ADDR_W  = LOCAL_W + IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic              err,
  output logic [IDX_W-1:0]  idx,
  output merge_t            mop,
  output logic [1:0]        rd_off
);
  logic [WIN_W-1:0]         win;
  logic [WIN_LSB-SUB_W-1:0] pad;
  logic [SUB_W-1:0]         sub;
  op_e                      op;
  logic                     align_ok;
  logic                     in_range;
  logic                     rd_ok;
  logic [DATA_W-1:0]        lane;
  logic [4:0]               sh_lane;
  logic [4:0]               sh_nib;
  logic [4:0]               sh_byt;
  logic [4:0]               sh_hlf;

  assign win    = addr[LOCAL_W-1:WIN_LSB];
  assign pad    = addr[WIN_LSB-1:SUB_W];
  assign sub    = addr[SUB_W-1:0];
  assign idx    = addr[ADDR_W-1:LOCAL_W];
  assign rd_off = sub[1:0];

  assign sh_lane = {sub[1:0], 3'b000};
  assign sh_nib  = {sub, 2'b00};
  assign sh_byt  = {sub[2:1], 3'b000};
  assign sh_hlf  = {sub[2], 4'b0000};

  always_comb begin
    unique case (win)
      WIN_DIRECT: op = OP_DIR;
      WIN_SET:    op = OP_SET;
      WIN_CLEAR:  op = OP_CLR;
      WIN_NIB:    op = OP_NIB;
      WIN_BYTE:   op = OP_BYT;
      WIN_HALF:   op = OP_HLF;
      default:    op = OP_BAD;
    endcase
  end

  always_comb begin
    lane = 32'h0000_00FF;
    if (size == SZ_HALF) lane = 32'h0000_FFFF;
    if (size == SZ_WORD) lane = '1;
  end

  always_comb begin
    align_ok = 1'b0;
    case (op)
      OP_DIR, OP_SET, OP_CLR:
        align_ok = !sub[2] && ((size == SZ_BYTE) ||
                               (size == SZ_HALF && !sub[0]) ||
                               (size == SZ_WORD && sub[1:0] == 2'b00));
      OP_NIB:  align_ok = (size == SZ_BYTE);
      OP_BYT:  align_ok = (size == SZ_HALF) && !sub[0];
      OP_HLF:  align_ok = (size == SZ_WORD) && (sub[1:0] == 2'b00);
      default: align_ok = 1'b0;
    endcase
  end

  assign in_range = {1'b0, idx} < (IDX_W+1)'(NUM_REGS);
  assign rd_ok    = (op == OP_DIR) && (size != SZ_WORD);
  assign err      = (op == OP_BAD) || (pad != '0) || !align_ok || !in_range ||
                    (!write && !rd_ok);

  always_comb begin
    mop = '0;
    case (op)
      OP_DIR: begin
        mop.mask = lane << sh_lane;
        mop.data = wdata << sh_lane;
      end
      OP_SET: begin
        mop.mask = (wdata & lane) << sh_lane;
        mop.data = '1;
      end
      OP_CLR: begin
        mop.mask = (wdata & lane) << sh_lane;
        mop.data = '0;
      end
      OP_NIB: begin
        mop.mask = {28'd0, wdata[7:4]} << sh_nib;
        mop.data = {28'd0, wdata[3:0]} << sh_nib;
      end
      OP_BYT: begin
        mop.mask = {24'd0, wdata[15:8]} << sh_byt;
        mop.data = {24'd0, wdata[7:0]} << sh_byt;
      end
      OP_HLF: begin
        mop.mask = {16'd0, wdata[31:16]} << sh_hlf;
        mop.data = {16'd0, wdata[15:0]} << sh_hlf;
      end
      default: mop = '0;
    endcase
  end
endmodule

// File: rtl/rmw_merge.sv
module rmw_merge
  import rmw_pkg::*;
(
  input  logic [DATA_W-1:0] old_word,
  input  merge_t            mop,
  output logic [DATA_W-1:0] new_word,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [1:0]        rd_off,
  input  logic [1:0]        rd_size,
  output logic [DATA_W-1:0] rd_field
);
  logic [DATA_W-1:0] rd_shift;

  assign new_word = (old_word & ~mop.mask) | (mop.data & mop.mask);

  assign rd_shift = rd_word >> {rd_off, 3'b000};

  always_comb begin
    if (rd_size == SZ_BYTE) rd_field = {24'd0, rd_shift[7:0]};
    else                    rd_field = {16'd0, rd_shift[15:0]};
  end
endmodule

// File: rtl/rmw_regfile.sv
module rmw_regfile
  import rmw_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0]   regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] wen;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign wen[g] = we && (widx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs_q[g] <= '0;
      else if (wen[g]) regs_q[g] <= wdata;
    end

    // R9: a register not being stored keeps its value
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wen[g] |=> $stable(regs_q[g]));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ridx == IDX_W'(i)) rdata = regs_q[i];
    end
  end

  // R11: a store touches at most one register
  p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wen));
endmodule

// File: rtl/atomic_rmw_bridge.sv
module atomic_rmw_bridge
  import rmw_pkg::*;
#(
  parameter int NUM_REGS = 6,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int ADDR_W  = LOCAL_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;

  state_e            state_q, state_d;
  logic              rsp_valid_d, rsp_err_d;
  logic [DATA_W-1:0] rsp_rdata_d;
  logic              rsp_valid_q, rsp_err_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  logic              hold_en, old_en, new_en, store_en;
  logic [IDX_W-1:0]  idx_q;
  merge_t            mop_q;
  logic [DATA_W-1:0] old_q, new_q;

  logic              dec_err;
  logic [IDX_W-1:0]  dec_idx;
  merge_t            dec_mop;
  logic [1:0]        dec_rd_off;

  logic [IDX_W-1:0]  rf_ridx;
  logic [DATA_W-1:0] rf_rdata;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rd_field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  rmw_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_decode (
    .addr   (req_addr),
    .write  (req_write),
    .size   (req_size),
    .wdata  (req_wdata),
    .err    (dec_err),
    .idx    (dec_idx),
    .mop    (dec_mop),
    .rd_off (dec_rd_off)
  );

  assign rf_ridx = (state_q == ST_IDLE) ? dec_idx : idx_q;

  rmw_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (store_en),
    .widx  (idx_q),
    .wdata (new_q),
    .ridx  (rf_ridx),
    .rdata (rf_rdata)
  );

  rmw_merge u_merge (
    .old_word (old_q),
    .mop      (mop_q),
    .new_word (merged),
    .rd_word  (rf_rdata),
    .rd_off   (dec_rd_off),
    .rd_size  (req_size),
    .rd_field (rd_field)
  );

  always_comb begin
    state_d     = state_q;
    rsp_valid_d = 1'b0;
    rsp_err_d   = 1'b0;
    rsp_rdata_d = '0;
    hold_en     = 1'b0;
    old_en      = 1'b0;
    new_en      = 1'b0;
    store_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (dec_err) begin
            rsp_valid_d = 1'b1;
            rsp_err_d   = 1'b1;
          end else if (!req_write) begin
            rsp_valid_d = 1'b1;
            rsp_rdata_d = rd_field;
          end else begin
            hold_en = 1'b1;
            state_d = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        old_en  = 1'b1;
        state_d = ST_MERGE;
      end
      ST_MERGE: begin
        new_en  = 1'b1;
        state_d = ST_STORE;
      end
      ST_STORE: begin
        store_en    = 1'b1;
        rsp_valid_d = 1'b1;
        state_d     = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_en) begin
      idx_q <= dec_idx;
      mop_q <= dec_mop;
    end
    if (old_en) old_q <= rf_rdata;
    if (new_en) new_q <= merged;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;

  // R11: once busy, the bridge stays busy for three cycles, then frees
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(req_ready) |=> !req_ready ##1 !req_ready ##1 req_ready);

  // R11: a store is followed by a clean response
  p_store_resp_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    store_en |=> rsp_valid && !rsp_err);

  // R9: an error response carries no data and no store precedes it
  p_err_clean_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_err |-> rsp_valid && (rsp_rdata == '0) && !$past(store_en));

  // R8: a response that is not an error appears only when the bridge is idle
  p_rsp_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> req_ready);
endmodule

// File: tb/atomic_rmw_bridge_tb.sv
module atomic_rmw_bridge_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NREG = 6;
  localparam int IW   = 3;
  localparam int AW   = 11 + IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_err;
  logic [31:0]   rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] model [NREG];

  always #2.5 clk = ~clk;

  atomic_rmw_bridge #(.NUM_REGS(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit legal(bit wr, int win, int pad, int sub, int sz, int idx);
    int nb;
    if (idx >= NREG || pad != 0 || sz == 3) return 0;
    nb = 1 << sz;
    case (win)
      0, 1, 2: begin
        if (sub > 3 || (sub % nb) != 0) return 0;
        if (!wr && (win != 0 || sz == 2)) return 0;
        return 1;
      end
      4: return wr && sz == 0;
      6: return wr && sz == 1 && (sub % 2) == 0;
      8: return wr && sz == 2 && (sub % 4) == 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] apply(logic [31:0] old, int win, int sub, int sz,
                                         logic [31:0] wd);
    logic [31:0] r;
    int lo, w, mo;
    r = old;
    mo = -1;
    case (win)
      0, 1, 2: begin lo = 8 * sub;       w = 8 << sz; end
      4:       begin lo = 4 * sub;       w = 4;  mo = 4;  end
      6:       begin lo = 8 * (sub / 2); w = 8;  mo = 8;  end
      default: begin lo = 16 * (sub / 4); w = 16; mo = 16; end
    endcase
    for (int k = 0; k < w; k++) begin
      if (win == 0) r[lo+k] = wd[k];
      else if (win == 1) begin if (wd[k]) r[lo+k] = 1'b1; end
      else if (win == 2) begin if (wd[k]) r[lo+k] = 1'b0; end
      else if (wd[mo+k]) r[lo+k] = wd[k];
    end
    return r;
  endfunction

  function automatic string tag_of(bit ok, bit wr, int win);
    if (!ok) return "R9";
    if (!wr) return "R8";
    case (win)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      4: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic access(bit wr, int idx, int win, int pad, int sub, int sz,
                        logic [31:0] wd, string tag);
    bit ok;
    int busy;
    logic [31:0] exp_rd;
    ok = legal(wr, win, pad, sub, sz, idx);
    exp_rd = 32'd0;
    if (ok && !wr) begin
      exp_rd = model[idx] >> (8 * sub);
      exp_rd = exp_rd & ((sz == 0) ? 32'hFF : 32'hFFFF);
    end
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_size  = 2'(sz);
    req_addr  = {IW'(idx), 4'(win), 4'(pad), 3'(sub)};
    req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!rsp_valid && busy < 10) begin
      if (!req_ready) busy++;
      @(negedge clk);
    end
    check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " rsp_err"}, 32'(rsp_err), 32'(!ok));
    check({tag, " rsp_rdata"}, rsp_rdata, exp_rd);
    check("R11 busy cycles", busy, (ok && wr) ? 3 : 0);
    check("R11 ready at response", 32'(req_ready), 32'd1);
    if (ok && wr) model[idx] = apply(model[idx], win, sub, sz, wd);
  endtask

  task automatic readback(int idx, string tag);
    access(1'b0, idx, 0, 0, 0, 1, 32'd0, tag);
    access(1'b0, idx, 0, 0, 2, 1, 32'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    int wins [8] = '{0, 1, 2, 4, 6, 8, 3, 5};
    seed_dummy = $urandom(32'd5150);
    for (int i = 0; i < NREG; i++) model[i] = 32'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R12 ready after reset", 32'(req_ready), 32'd1);
    check("R12 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    for (int i = 0; i < NREG; i++) readback(i, "R12");

    // direct lanes
    access(1, 0, 0, 0, 0, 2, 32'h1234_5678, "R2");
    access(1, 0, 0, 0, 2, 1, 32'h0000_ABCD, "R2");
    access(1, 0, 0, 0, 3, 0, 32'hFFFF_FF66, "R2");
    access(0, 0, 0, 0, 3, 0, 32'd0, "R8");
    access(0, 0, 0, 0, 2, 1, 32'd0, "R8");
    readback(0, "R2");
    // set / clear
    access(1, 1, 1, 0, 0, 2, 32'hAAAA_AAAA, "R3");
    access(1, 1, 2, 0, 0, 2, 32'h00FF_0000, "R4");
    access(1, 1, 1, 0, 2, 0, 32'h0000_0055, "R3");
    access(1, 1, 2, 0, 1, 1, 32'h0000_000F, "R4");
    readback(1, "R4");
    // masked windows at extreme offsets
    access(1, 2, 8, 0, 0, 2, 32'hFFFF_5555, "R7");
    access(1, 2, 8, 0, 4, 2, 32'h01FF_01AA, "R7");
    access(1, 2, 6, 0, 0, 1, 32'h0000_FF00, "R6");
    access(1, 2, 6, 0, 2, 1, 32'h0000_FF11, "R6");
    access(1, 2, 6, 0, 6, 1, 32'h0000_FF33, "R6");
    access(1, 2, 4, 0, 0, 0, 32'h0000_00F7, "R5");
    access(1, 2, 4, 0, 1, 0, 32'h0000_00F4, "R5");
    access(1, 2, 4, 0, 7, 0, 32'h0000_0059, "R5");
    readback(2, "R5");
    // illegal accesses
    access(0, 0, 0, 0, 0, 2, 32'd0, "R8");
    access(1, 3, 6, 0, 0, 0, 32'h0000_00FF, "R9");
    access(0, 1, 1, 0, 0, 0, 32'd0, "R9");
    access(1, 3, 0, 0, 1, 1, 32'h0000_FFFF, "R9");
    access(1, 3, 3, 0, 0, 2, 32'hFFFF_FFFF, "R1");
    access(1, 3, 0, 5, 0, 2, 32'hFFFF_FFFF, "R1");
    access(1, 3, 0, 0, 4, 0, 32'h0000_00FF, "R1");
    access(1, 6, 0, 0, 0, 2, 32'hFFFF_FFFF, "R10");
    access(1, 7, 1, 0, 0, 2, 32'hFFFF_FFFF, "R10");
    readback(3, "R9");

    for (int n = 0; n < 500; n++) begin
      bit wr;
      int idx, win, pad, sub, sz;
      logic [31:0] wd;
      wr  = ($urandom_range(0, 3) != 0);
      idx = $urandom_range(0, 7);
      win = wins[$urandom_range(0, 7)];
      pad = ($urandom_range(0, 15) == 0) ? $urandom_range(1, 15) : 0;
      sub = $urandom_range(0, 7);
      sz  = $urandom_range(0, 3);
      wd  = $urandom;
      access(wr, idx, win, pad, sub, sz, wd,
             tag_of(legal(wr, win, pad, sub, sz, idx), wr, win));
      if (idx < NREG) readback(idx, "R9");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule